// File: doc/BRIEF.md
# Disk Record Checksum Checker

This block checks the integrity of one record of disk data at a time. A read synchronizer delivers 16-bit words, one per strobe. When the synchronizer reports word alignment for a new record, it pulses a start input. With that pulse it also supplies the record length in words and a flag that marks the final record of the sector. The checker then folds each data word into a running residue. The word that follows the data words is taken as the stored checksum word.

The residue starts from a fixed nonzero seed, octal 0521. Each data word is combined into it with XOR. The stored checksum word is then subtracted from the residue, and the record is good when the result is zero. The block reports the outcome as a one-cycle completion pulse together with a held pass bit. When the final record of a sector checks good, two sticky status outputs are raised: transfer-off and sync-held. They tell the controller to stop the transfer and to stop re-synchronizing. Typical record lengths are two words for a header and twenty for the first record, but any length from zero up to the counter limit is accepted.

Top module: `disk_rec_cksum`

## Requirements
- R1: A cycle with `start_i` high loads the residue with octal 0521 (hex 0151), loads the word counter from `len_i` and latches `last_i`. This holds even while a record is in progress, which restarts it. A word strobe in the same cycle as `start_i` is not consumed.
- R2: While a record is active, each of the first `len_i` word strobes is a data word and is XORed into the residue.
- R3: The strobe after the data words is the checksum word. The record passes exactly when the residue minus that word is zero modulo 2^16, that is, when the word equals the residue.
- R4: `done_o` is high for exactly the one cycle after the edge that consumes the checksum word. `pass_o` carries that record's result from that cycle until the next completion.
- R5: `xfer_off_o` and `sync_hold_o` both rise together, in the cycle after the checksum edge, only when a record started with `last_i` high passes. A failing final record, or a passing non-final record, leaves them unchanged. Once set they stay set until reset.
- R6: Word strobes while no record is active are ignored: they produce no `done_o`, and they do not alter the result of the next record.
- R7: A record length of zero makes the first strobe after start the checksum word, so that record passes when that word equals octal 0521.
- R8: A synchronous reset (`rst` high at a clock edge) returns the block to idle with `busy_o`, `done_o`, `pass_o`, `xfer_off_o` and `sync_hold_o` all low.
- R9: `busy_o` is high from the cycle after a start until the checksum word is consumed, and is low afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Record start at word alignment |
| len_i | input | CNT_W (8) | Number of data words in the record, sampled on start |
| last_i | input | 1 | Record is the last of the sector, sampled on start |
| word_valid_i | input | 1 | Word strobe from the read synchronizer |
| word_i | input | WORD_W (16) | Word delivered with the strobe |
| busy_o | output | 1 | A record is being checked |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Result of the most recent record |
| xfer_off_o | output | 1 | Sticky transfer-off status |
| sync_hold_o | output | 1 | Sticky sync-held status |

## Verification
The hardest situations to reach are those where control events collide: a start that arrives together with a word strobe, and a start that arrives partway through a record. Both must leave the following record's check intact. The bench reaches them by raising the start and strobe lines in the same cycle, and by abandoning a longer record after two words before starting a short one. In each case the following checksum is computed only from the words that should count. The sticky status is reached through an ordered series of records: a failing final record, a passing non-final record, a passing final record, and then a failing record. The series shows that only the qualifying event sets the status and that nothing after it clears the status.

// File: rtl/ckc_pkg.sv
package ckc_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_DATA = 1'b1
    } ckc_state_e;
endpackage

// File: rtl/ckc_len_counter.sv
module ckc_len_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] len_i,
    input  logic             dec_i,
    output logic             zero_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_regs_t;

    cnt_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (load_i) begin
            r_d.cnt = len_i;
        end else if (dec_i && (r_q.cnt != '0)) begin
            r_d.cnt = r_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign zero_o = (r_q.cnt == '0);

    // R1: the length is captured on start
    p_len_load_r1: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (r_q.cnt == $past(len_i)));

    // R2: a consumed data word lowers the remaining count by one
    p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
        (dec_i && !load_i && !zero_o) |=> (r_q.cnt == $past(r_q.cnt) - 1'b1));
endmodule

// File: rtl/ckc_accum.sv
module ckc_accum #(
    parameter int              WORD_W = 16,
    parameter logic [WORD_W-1:0] SEED = 16'o521
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic              fold_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [WORD_W-1:0] acc_o
);
    typedef struct packed {
        logic [WORD_W-1:0] acc;
    } acc_regs_t;

    acc_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (load_i) begin
            r_d.acc = SEED;
        end else if (fold_i) begin
            r_d.acc = r_q.acc ^ word_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign acc_o = r_q.acc;

    // R1: start puts the seed in the residue
    p_seed_load_r1: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (acc_o == SEED));

    // R6: without a load or fold the residue holds
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !fold_i) |=> $stable(acc_o));
endmodule

// File: rtl/ckc_status.sv
module ckc_status (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    output logic xfer_off_o,
    output logic sync_hold_o
);
    typedef struct packed {
        logic xfer_off;
        logic sync_hold;
    } st_regs_t;

    st_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (set_i) begin
            r_d.xfer_off  = 1'b1;
            r_d.sync_hold = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign xfer_off_o  = r_q.xfer_off;
    assign sync_hold_o = r_q.sync_hold;

    // R5: the status bits are sticky and move together
    p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        xfer_off_o |=> xfer_off_o);
    p_paired_r5: assert property (@(posedge clk) disable iff (rst)
        xfer_off_o == sync_hold_o);
endmodule

// File: rtl/disk_rec_cksum.sv
module disk_rec_cksum #(
    parameter int                WORD_W = 16,
    parameter int                CNT_W  = 8,
    parameter logic [WORD_W-1:0] SEED   = 16'o521
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  len_i,
    input  logic              last_i,
    input  logic              word_valid_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              pass_o,
    output logic              xfer_off_o,
    output logic              sync_hold_o
);
    import ckc_pkg::*;

    typedef struct packed {
        ckc_state_e state;
        logic       last;
        logic       done;
        logic       pass;
    } ctl_regs_t;

    ctl_regs_t r_d, r_q;

    logic              cnt_zero;
    logic [WORD_W-1:0] acc;
    logic [WORD_W-1:0] residue;
    logic              active_word;
    logic              data_word;
    logic              chk_word;
    logic              good;
    logic              status_set;

    assign active_word = word_valid_i && !start_i && (r_q.state == ST_DATA);
    assign data_word   = active_word && !cnt_zero;
    assign chk_word    = active_word && cnt_zero;
    assign residue     = acc - word_i;
    assign good        = (residue == '0);
    assign status_set  = chk_word && good && r_q.last;

    ckc_len_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .load_i (start_i),
        .len_i  (len_i),
        .dec_i  (data_word),
        .zero_o (cnt_zero)
    );

    ckc_accum #(
        .WORD_W (WORD_W),
        .SEED   (SEED)
    ) u_acc (
        .clk    (clk),
        .rst    (rst),
        .load_i (start_i),
        .fold_i (data_word),
        .word_i (word_i),
        .acc_o  (acc)
    );

    ckc_status u_stat (
        .clk         (clk),
        .rst         (rst),
        .set_i       (status_set),
        .xfer_off_o  (xfer_off_o),
        .sync_hold_o (sync_hold_o)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (start_i) begin
            r_d.state = ST_DATA;
            r_d.last  = last_i;
        end else if (chk_word) begin
            r_d.state = ST_IDLE;
            r_d.done  = 1'b1;
            r_d.pass  = good;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o = (r_q.state == ST_DATA);
    assign done_o = r_q.done;
    assign pass_o = r_q.pass;

    // R4: completion is a single-cycle pulse
    p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R4: the result is held between completions
    p_pass_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> (pass_o == $past(pass_o)));

    // R9: a completion ends the busy period unless a new start came
    p_busy_end_r9: assert property (@(posedge clk) disable iff (rst)
        (done_o && !$past(start_i)) |-> !busy_o);

    // R6: no completion without an active record in the cycle before
    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i) |=> !done_o);

    // R5: status rises only together with a passing completion
    p_status_cause_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(xfer_off_o) |-> (done_o && pass_o));
endmodule

// File: tb/disk_rec_cksum_bench.sv
module disk_rec_cksum_bench;
    localparam logic [15:0] SEED_V = 16'o521;

    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic [7:0]  len_i;
    logic        last_i;
    logic        word_valid_i;
    logic [15:0] word_i;
    logic        busy_o, done_o, pass_o, xfer_off_o, sync_hold_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    disk_rec_cksum u_disk_rec_cksum (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .len_i        (len_i),
        .last_i       (last_i),
        .word_valid_i (word_valid_i),
        .word_i       (word_i),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .pass_o       (pass_o),
        .xfer_off_o   (xfer_off_o),
        .sync_hold_o  (sync_hold_o)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] gen_word(input int salt, input int i);
        return 16'(salt * 16'h3b71) ^ 16'(i * 16'h1357) ^ 16'(i << 9);
    endfunction

    task automatic do_start(input int len, input bit last);
        @(negedge clk);
        start_i = 1'b1;
        len_i   = 8'(len);
        last_i  = last;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic send_word(input logic [15:0] w);
        if (!clk) @(posedge clk);
        @(negedge clk);
        word_valid_i = 1'b1;
        word_i       = w;
        @(posedge clk);
        #1;
    endtask

    task automatic release_bus();
        @(negedge clk);
        word_valid_i = 1'b0;
        word_i       = 16'h0;
    endtask

    // Sends len data words then a checksum; returns after the checksum edge.
    task automatic send_body(input string req, input int len, input int salt,
                             input bit good);
        logic [15:0] acc = SEED_V;
        for (int i = 0; i < len; i++) begin
            logic [15:0] w = gen_word(salt, i);
            acc = acc ^ w;
            send_word(w);
        end
        check(req, "busy before checksum", busy_o, 1'b1);
        send_word(good ? acc : (acc ^ 16'h0040));
        check(req, "done after checksum", done_o, 1'b1);
        check(req, "pass result", pass_o, good);
        check("R9", "busy after checksum", busy_o, 1'b0);
        release_bus();
        check(req, "done still high mid-cycle", done_o, 1'b1);
        @(posedge clk);
        #1;
        check("R4", "done pulse ends", done_o, 1'b0);
        check("R4", "pass held", pass_o, good);
    endtask

    task automatic t_reset_state();
        check("R8", "busy", busy_o, 1'b0);
        check("R8", "done", done_o, 1'b0);
        check("R8", "pass", pass_o, 1'b0);
        check("R8", "xfer_off", xfer_off_o, 1'b0);
        check("R8", "sync_hold", sync_hold_o, 1'b0);
    endtask

    task automatic t_header_good();
        do_start(2, 1'b0);
        check("R9", "busy after start", busy_o, 1'b1);
        send_body("R3", 2, 1, 1'b1);
    endtask

    task automatic t_long_good();
        do_start(20, 1'b0);
        send_body("R2", 20, 7, 1'b1);
    endtask

    task automatic t_bad();
        do_start(5, 1'b0);
        send_body("R3", 5, 3, 1'b0);
    endtask

    task automatic t_zero_len();
        do_start(0, 1'b0);
        send_word(SEED_V);
        check("R7", "done on first strobe", done_o, 1'b1);
        check("R7", "pass with seed", pass_o, 1'b1);
        release_bus();
        do_start(0, 1'b0);
        send_word(16'h0000);
        check("R7", "fail with zero word", pass_o, 1'b0);
        release_bus();
    endtask

    task automatic t_idle_ignored();
        for (int i = 0; i < 3; i++) begin
            send_word(16'hbeef + 16'(i));
            check("R6", "no done when idle", done_o, 1'b0);
            check("R6", "not busy when idle", busy_o, 1'b0);
        end
        release_bus();
        do_start(3, 1'b0);
        send_body("R6", 3, 11, 1'b1);
    endtask

    task automatic t_start_collide();
        @(negedge clk);
        start_i = 1'b1;
        len_i = 8'd2;
        last_i = 1'b0;
        word_valid_i = 1'b1;
        word_i = 16'h5a5a;
        @(negedge clk);
        start_i = 1'b0;
        word_valid_i = 1'b0;
        send_body("R1", 2, 13, 1'b1);
    endtask

    task automatic t_restart();
        do_start(5, 1'b0);
        send_word(16'h1111);
        send_word(16'h2222);
        release_bus();
        do_start(2, 1'b0);
        send_body("R1", 2, 17, 1'b1);
    endtask

    task automatic t_status();
        do_start(2, 1'b1);
        send_body("R5", 2, 21, 1'b0);
        check("R5", "xfer_off after failing last", xfer_off_o, 1'b0);
        do_start(2, 1'b0);
        send_body("R5", 2, 22, 1'b1);
        check("R5", "xfer_off after good non-last", xfer_off_o, 1'b0);
        do_start(2, 1'b1);
        send_body("R5", 2, 23, 1'b1);
        check("R5", "xfer_off after good last", xfer_off_o, 1'b1);
        check("R5", "sync_hold after good last", sync_hold_o, 1'b1);
        do_start(4, 1'b0);
        send_body("R5", 4, 24, 1'b0);
        check("R5", "xfer_off sticky", xfer_off_o, 1'b1);
        check("R5", "sync_hold sticky", sync_hold_o, 1'b1);
    endtask

    task automatic t_reset_clears();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        t_reset_state();
    endtask

    initial begin
        rst = 1'b1;
        start_i = 1'b0;
        len_i = '0;
        last_i = 1'b0;
        word_valid_i = 1'b0;
        word_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset_state();
        t_header_good();
        t_long_good();
        t_bad();
        t_zero_len();
        t_idle_ignored();
        t_start_collide();
        t_restart();
        t_status();
        t_reset_clears();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule